// File: doc/BRIEF.md
# EPROM word programming sequencer

This controller writes a run of words into a one-time-programmable memory array. A requester hands it a base address and a word count. The controller asks a data source for each word by its offset within the run. It then drives the memory's address, write data, chip enable, output enable and program strobe, and it raises flags that switch on the programming supply and select a supply level.

For each word the controller first reads the cell. A target that would need a 0 turned back into a 1 is rejected at once, without any pulse. A target that already matches costs no pulse. Any other word gets fixed-width program pulses. Each pulse is followed by a verify read, and the loop stops at the first matching read or after a bounded number of pulses. No extra pulse is given after a good verify.

Once every word is written, the whole run is read back twice, each pass under a different supply-level flag. The controller ends with a done or a fail flag, and on failure it gives the address that failed. All intervals are whole microseconds, counted in clock cycles through a cycles-per-microsecond parameter.

Top module: `otp_burn_seq`

## Requirements
- R1: After reset, req_ready=1, busy=0, done=0, fail=0, mem_pgm_n=1, mem_ce_n=1, mem_oe_n=1, vpp_en=0 and vcc_mode=2'b00.
- R2: Each program pulse holds mem_pgm_n low for exactly PW_US*CYC_PER_US cycles, which is 100 µs by default and so inside 95 to 105 µs.
- R3: Address, write data with mem_wdrive=1, mem_ce_n=0 and vpp_en=1 are steady for at least SU_US (2 µs) before mem_pgm_n falls. mem_wdrive stays 1 for at least HD_US (2 µs) after mem_pgm_n rises. At least GP_US (2 µs) pass between mem_wdrive falling and mem_oe_n falling.
- R4: After every pulse, a verify read is made with mem_ce_n=0, mem_oe_n=0 and mem_pgm_n=1. A match moves on to the next word, so a word that needs k pulses (k ≤ 25) receives exactly k pulses.
- R5: The pulse count restarts for each word. If the verify after the 25th pulse (MAX_PULSES) still mismatches, the sequence ends with fail=1 and fail_addr set to that word's address.
- R6: Before pulsing, the word is read. If the target has a 1 where the cell holds 0, the sequence ends with fail=1 and fail_addr set to that address, after zero pulses. A cell that already equals the target gets zero pulses.
- R7: Word i of a run (i = 0 .. count-1) goes to address (base + i) mod 2^AW, and src_idx = i selects its data on src_data.
- R8: After the last word, all words are read and compared in two passes: the first with vcc_mode=2'b10 and the second with vcc_mode=2'b11. A mismatch gives fail=1 and fail_addr; if both passes are clean, done=1. During programming vcc_mode=2'b01.
- R9: req_ready=1 only while idle. A request is taken on req_valid && req_ready, and requests made while busy are ignored. done and fail hold until the next request is accepted. A count of 0 gives done=1 with no pulse.
- R10: mem_pgm_n is low only while mem_ce_n=0, vpp_en=1, mem_wdrive=1 and mem_oe_n=1. mem_oe_n=0 never coincides with mem_wdrive=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Controller idle, request accepted |
| req_base | input | AW | First address of the run |
| req_count | input | AW+1 | Number of words |
| src_idx | output | AW | Offset of the word whose data is wanted |
| src_data | input | DW | Target data for src_idx |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data to program |
| mem_wdrive | output | 1 | Controller drives the data bus |
| mem_rdata | input | DW | Data read from memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_pgm_n | output | 1 | Program strobe, active low |
| vpp_en | output | 1 | Programming supply on |
| vcc_mode | output | 2 | 00 idle, 01 program, 10 high check, 11 low check |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with success |
| fail | output | 1 | Run ended with failure |
| fail_addr | output | AW | Address that failed |

## Verification
A wrong state or timer load shows up at the memory pins within the same pulse: a strobe of the wrong length, a verify read without the gap after data release, or data released too soon after the strobe. A pulse counter that is off by one shows up as a word getting one pulse too many or too few, or as a failing word being given up at 24 or 26 pulses. A wrong index or pass bit shows as a wrong address, as a check pass skipped, or as the passes running in the wrong order before done rises. These are visible as soon as the run ends.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PRERD, S_SETUP, S_PULSE, S_HOLD, S_GAP, S_VERIFY, S_NEXT, S_CHK
  } seq_state_t;

  localparam logic [1:0] VCC_IDLE = 2'b00;
  localparam logic [1:0] VCC_PROG = 2'b01;
  localparam logic [1:0] VCC_CHKH = 2'b10;
  localparam logic [1:0] VCC_CHKL = 2'b11;

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/otp_seq_timer.sv
module otp_seq_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/otp_word_cmp.sv
module otp_word_cmp #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] tgt,
  output logic          match,
  output logic          blocked
);
  // a 1 in the target over a 0 in the cell cannot be written
  function automatic logic needs_set(logic [DW-1:0] c, logic [DW-1:0] t);
    return |(~c & t);
  endfunction

  assign match   = (cur == tgt);
  assign blocked = needs_set(cur, tgt);
endmodule

// File: rtl/otp_addr_gen.sv
module otp_addr_gen #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base,
  input  logic [AW:0]   count,
  input  logic [AW-1:0] idx,
  output logic [AW-1:0] addr,
  output logic          last
);
  function automatic logic [AW-1:0] wrap_add(logic [AW-1:0] b, logic [AW-1:0] i);
    return b + i;
  endfunction

  assign addr = wrap_add(base, idx);
  assign last = ({1'b0, idx} == (count - (AW+1)'(1)));
endmodule

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
  import otp_seq_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int CYC_PER_US = 50,
  parameter int PW_US      = 100,
  parameter int SU_US      = 2,
  parameter int HD_US      = 2,
  parameter int GP_US      = 2,
  parameter int RD_US      = 1,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_base,
  input  logic [AW:0]   req_count,
  output logic [AW-1:0] src_idx,
  input  logic [DW-1:0] src_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_wdrive,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_pgm_n,
  output logic          vpp_en,
  output logic [1:0]    vcc_mode,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr
);
  localparam int LONGEST = imax(imax(PW_US, SU_US), imax(imax(HD_US, GP_US), RD_US)) * CYC_PER_US;
  localparam int TW      = $clog2(LONGEST + 1);
  localparam int PCW     = $clog2(MAX_PULSES + 1);

  function automatic logic [TW-1:0] dur_cyc(seq_state_t s);
    case (s)
      S_PRERD, S_VERIFY, S_CHK: return TW'(RD_US * CYC_PER_US);
      S_SETUP:                  return TW'(SU_US * CYC_PER_US);
      S_PULSE:                  return TW'(PW_US * CYC_PER_US);
      S_HOLD:                   return TW'(HD_US * CYC_PER_US);
      S_GAP:                    return TW'(GP_US * CYC_PER_US);
      default:                  return TW'(1);
    endcase
  endfunction

  seq_state_t    st, nxt;
  logic [AW-1:0] base_q, idx_q, fail_addr_q;
  logic [AW:0]   cnt_q;
  logic [PCW-1:0] pulses_q;
  logic          pass_q, done_q, fail_q;

  // named events for assertions and readability
  logic t_exp, w_match, w_blocked, w_last;
  logic ev_accept, ev_fail, ev_ok, ev_chk_step, ld;
  logic [TW-1:0] ld_val;

  otp_seq_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val), .expired(t_exp)
  );

  otp_word_cmp #(.DW(DW)) u_cmp (
    .cur(mem_rdata), .tgt(src_data), .match(w_match), .blocked(w_blocked)
  );

  otp_addr_gen #(.AW(AW)) u_addr (
    .base(base_q), .count(cnt_q), .idx(idx_q), .addr(mem_addr), .last(w_last)
  );

  assign ev_accept   = (st == S_IDLE) && req_valid;
  assign ev_fail     = t_exp && (((st == S_PRERD) && w_blocked) ||
                                 ((st == S_VERIFY) && !w_match && (pulses_q == PCW'(MAX_PULSES))) ||
                                 ((st == S_CHK) && !w_match));
  assign ev_ok       = t_exp && (st == S_CHK) && w_match && w_last && pass_q;
  assign ev_chk_step = t_exp && (st == S_CHK) && w_match && !(w_last && pass_q);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:   if (req_valid && (req_count != '0)) nxt = S_PRERD;
      S_PRERD:  if (t_exp) nxt = w_blocked ? S_IDLE : (w_match ? S_NEXT : S_SETUP);
      S_SETUP:  if (t_exp) nxt = S_PULSE;
      S_PULSE:  if (t_exp) nxt = S_HOLD;
      S_HOLD:   if (t_exp) nxt = S_GAP;
      S_GAP:    if (t_exp) nxt = S_VERIFY;
      S_VERIFY: if (t_exp) nxt = w_match ? S_NEXT :
                                 ((pulses_q == PCW'(MAX_PULSES)) ? S_IDLE : S_SETUP);
      S_NEXT:   nxt = w_last ? S_CHK : S_PRERD;
      S_CHK:    if (ev_fail || ev_ok) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
    ld     = (nxt != st) || ev_chk_step;
    ld_val = dur_cyc(nxt) - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      base_q      <= '0;
      cnt_q       <= '0;
      idx_q       <= '0;
      pulses_q    <= '0;
      pass_q      <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      fail_addr_q <= '0;
    end else begin
      st <= nxt;
      if (ev_accept) begin
        base_q <= req_base;
        cnt_q  <= req_count;
        idx_q  <= '0;
        pass_q <= 1'b0;
        done_q <= (req_count == '0);
        fail_q <= 1'b0;
      end
      if (st == S_PRERD) pulses_q <= '0;
      if ((st == S_SETUP) && t_exp) pulses_q <= pulses_q + PCW'(1);
      if (st == S_NEXT) idx_q <= w_last ? '0 : idx_q + AW'(1);
      if (ev_chk_step) begin
        if (w_last) begin
          idx_q  <= '0;
          pass_q <= 1'b1;
        end else begin
          idx_q <= idx_q + AW'(1);
        end
      end
      if (ev_fail) begin
        fail_q      <= 1'b1;
        fail_addr_q <= mem_addr;
      end
      if (ev_ok) done_q <= 1'b1;
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign busy       = (st != S_IDLE);
  assign src_idx    = idx_q;
  assign mem_wdata  = src_data;
  assign mem_wdrive = (st == S_SETUP) || (st == S_PULSE) || (st == S_HOLD);
  assign mem_ce_n   = (st == S_IDLE);
  assign mem_oe_n   = !((st == S_PRERD) || (st == S_VERIFY) || (st == S_CHK));
  assign mem_pgm_n  = (st != S_PULSE);
  assign vpp_en     = (st != S_IDLE) && (st != S_CHK);
  assign vcc_mode   = (st == S_IDLE) ? VCC_IDLE :
                      (st == S_CHK)  ? (pass_q ? VCC_CHKL : VCC_CHKH) : VCC_PROG;
  assign done       = done_q;
  assign fail       = fail_q;
  assign fail_addr  = fail_addr_q;
endmodule

// File: rtl/otp_burn_seq_chk.sv
module otp_burn_seq_chk #(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int CYC_PER_US = 50,
  parameter int PW_US      = 100,
  parameter int SU_US      = 2,
  parameter int HD_US      = 2,
  parameter int GP_US      = 2,
  parameter int MAX_PULSES = 25
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          busy,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_wdrive,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_pgm_n,
  input logic          vpp_en
);
  localparam logic [31:0] PW_C = 32'(PW_US * CYC_PER_US);
  localparam logic [31:0] SU_C = 32'(SU_US * CYC_PER_US);
  localparam logic [31:0] HD_C = 32'(HD_US * CYC_PER_US);
  localparam logic [31:0] GP_C = 32'(GP_US * CYC_PER_US);

  logic [31:0] low_cnt, stbl_cnt, since_rise, since_rel, addr_pulses;
  logic [AW+DW+2:0] ctx_prev;
  logic [AW-1:0] addr_prev;
  logic pgm_prev, drv_prev;
  wire  [AW+DW+2:0] ctx_now = {mem_addr, mem_wdata, mem_wdrive, mem_ce_n, vpp_en};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0; stbl_cnt <= '0; since_rise <= '1; since_rel <= '1;
      addr_pulses <= '0; ctx_prev <= '0; addr_prev <= '0;
      pgm_prev <= 1'b1; drv_prev <= 1'b0;
    end else begin
      ctx_prev  <= ctx_now;
      addr_prev <= mem_addr;
      pgm_prev  <= mem_pgm_n;
      drv_prev  <= mem_wdrive;
      low_cnt   <= mem_pgm_n ? '0 : low_cnt + 1;
      if (ctx_now != ctx_prev)   stbl_cnt <= '0;
      else if (stbl_cnt != '1)   stbl_cnt <= stbl_cnt + 1;
      if (mem_pgm_n && !pgm_prev) since_rise <= '0;
      else if (since_rise != '1)  since_rise <= since_rise + 1;
      if (!mem_wdrive && drv_prev) since_rel <= '0;
      else if (since_rel != '1)    since_rel <= since_rel + 1;
      if (mem_addr != addr_prev)          addr_pulses <= '0;
      else if (!mem_pgm_n && pgm_prev)    addr_pulses <= addr_pulses + 1;
    end
  end

  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_pgm_n) |-> (low_cnt == PW_C));
  a_r3_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_pgm_n) |-> (stbl_cnt >= SU_C - 1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wdrive) |-> (since_rise >= HD_C - 1));
  a_r3_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_oe_n) |-> (since_rel >= GP_C - 1));
  a_r5_pulse_limit: assert property (@(posedge clk) disable iff (!rst_n)
    addr_pulses <= 32'(MAX_PULSES));
  a_r10_strobe_ctx: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_pgm_n |-> (!mem_ce_n && vpp_en && mem_wdrive && mem_oe_n));
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wdrive && !mem_oe_n));
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!busy && mem_ce_n && mem_pgm_n));
endmodule

bind otp_burn_seq otp_burn_seq_chk #(
  .AW(AW), .DW(DW), .CYC_PER_US(CYC_PER_US), .PW_US(PW_US), .SU_US(SU_US),
  .HD_US(HD_US), .GP_US(GP_US), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdrive(mem_wdrive),
  .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n), .vpp_en(vpp_en)
);

// File: tb/otp_burn_seq_tb.sv
module otp_burn_seq_tb;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CYC = 2;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_base = '0;
  logic [AW:0] req_count = '0;
  logic req_ready, mem_wdrive, mem_ce_n, mem_oe_n, mem_pgm_n, vpp_en, busy, done, fail;
  logic [AW-1:0] src_idx, mem_addr, fail_addr;
  logic [DW-1:0] src_data, mem_wdata, mem_rdata;
  logic [1:0] vcc_mode;

  always #2.5 clk = ~clk;

  // memory model
  logic [DW-1:0] cells [16];
  int seen [16];
  int need_n = 1;
  logic [DW-1:0] seed = 16'hA5A5;
  logic weak_en = 0;
  logic [AW-1:0] weak_a = '0;

  assign src_data  = seed ^ {4{src_idx}};
  assign mem_rdata = (!mem_ce_n && !mem_oe_n) ?
    (cells[mem_addr] ^ ((weak_en && vcc_mode == 2'b11 && mem_addr == weak_a) ? 16'h0001 : 16'h0000)) : '0;

  always @(negedge mem_pgm_n) seen[mem_addr] = seen[mem_addr] + 1;
  always @(posedge mem_pgm_n)
    if (vpp_en === 1'b1 && mem_ce_n === 1'b0 && seen[mem_addr] >= need_n)
      cells[mem_addr] = cells[mem_addr] & mem_wdata;

  // port-level monitors
  int lw = 0, last_w = 0, su = 0, last_su = 0;
  logic saw_hi = 0, saw_lo = 0, bad_order = 0;
  always @(negedge clk) begin
    if (!mem_pgm_n) lw = lw + 1;
    else if (lw != 0) begin last_w = lw; lw = 0; end
    if (!mem_wdrive) su = 0;
    else if (mem_pgm_n) su = su + 1;
    else if (su != 0) begin last_su = su; su = 0; end
    if (!mem_oe_n && vcc_mode == 2'b10) saw_hi = 1;
    if (!mem_oe_n && vcc_mode == 2'b11) begin saw_lo = 1; if (!saw_hi) bad_order = 1; end
  end

  otp_burn_seq #(.AW(AW), .DW(DW), .CYC_PER_US(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_count(req_count), .src_idx(src_idx), .src_data(src_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdrive(mem_wdrive),
    .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_pgm_n(mem_pgm_n), .vpp_en(vpp_en), .vcc_mode(vcc_mode), .busy(busy),
    .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  int n_chk = 0, n_err = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_model(input int needv, input logic [DW-1:0] s);
    for (int i = 0; i < 16; i++) begin cells[i] = 16'hFFFF; seen[i] = 0; end
    need_n = needv; seed = s; weak_en = 0;
    saw_hi = 0; saw_lo = 0; bad_order = 0; last_w = 0; last_su = 0;
  endtask

  task automatic run_job(input logic [AW-1:0] b, input logic [AW:0] c);
    @(negedge clk);
    req_valid = 1; req_base = b; req_count = c;
    @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] word_of(input logic [DW-1:0] s, input int i);
    logic [3:0] k = 4'(i);
    return s ^ {k, k, k, k};
  endfunction

  // {base[4], count[5], seed[16], need[5], expect_fail[1], fail_addr[4]}
  localparam int NV = 4;
  localparam logic [34:0] VECS [NV] = '{
    {4'd0,  5'd4, 16'hA5A5, 5'd1,  1'b0, 4'd0},
    {4'd6,  5'd3, 16'h0F0F, 5'd3,  1'b0, 4'd0},
    {4'd14, 5'd4, 16'h1234, 5'd25, 1'b0, 4'd0},
    {4'd2,  5'd2, 16'h00FF, 5'd26, 1'b1, 4'd2}
  };

  logic [34:0] e;
  int bad_cells, bad_pulses;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 busy/done/fail", int'({busy, done, fail}), 0);
    chk("R1 strobes", int'({mem_pgm_n, mem_ce_n, mem_oe_n}), 7);
    chk("R1 supplies", int'({vpp_en, vcc_mode}), 0);

    for (int v = 0; v < NV; v++) begin
      e = VECS[v];
      clear_model(int'(e[9:5]), e[25:10]);
      run_job(e[34:31], e[30:26]);
      if (!e[4]) begin
        bad_cells = 0; bad_pulses = 0;
        for (int i = 0; i < int'(e[30:26]); i++) begin
          if (cells[4'(int'(e[34:31]) + i)] != word_of(e[25:10], i)) bad_cells++;
          if (seen[4'(int'(e[34:31]) + i)] != int'(e[9:5])) bad_pulses++;
        end
        chk("R7/R8 done", int'({done, fail}), 2);
        chk("R7 contents at base+i", bad_cells, 0);
        chk("R4 pulses equal need", bad_pulses, 0);
        chk("R8 both passes in order", int'({saw_hi, saw_lo, bad_order}), 6);
        chk("R2 pulse width", last_w, 100 * CYC);
        chk("R3 setup cycles", last_su, 2 * CYC);
      end else begin
        chk("R5 fail flags", int'({done, fail}), 1);
        chk("R5 fail_addr", int'(fail_addr), int'(e[3:0]));
        chk("R5 pulse limit", seen[e[3:0]], 25);
      end
    end

    // R6 blocked word: 0 in cell where target has 1
    clear_model(1, 16'hFFF0);
    cells[9] = 16'h00F0;
    run_job(4'd9, 5'd1);
    chk("R6 blocked fail", int'({done, fail}), 1);
    chk("R6 blocked fail_addr", int'(fail_addr), 9);
    chk("R6 blocked no pulse", seen[9], 0);

    // R6 already matching word
    clear_model(1, 16'h5A5A);
    cells[5] = 16'h5A5A;
    run_job(4'd5, 5'd1);
    chk("R6 match done", int'({done, fail}), 2);
    chk("R6 match no pulse", seen[5], 0);

    // R8 low-level pass failure
    clear_model(2, 16'h0F0F);
    weak_en = 1; weak_a = 4'd11;
    run_job(4'd10, 5'd3);
    chk("R8 low pass fail", int'({done, fail}), 1);
    chk("R8 low pass fail_addr", int'(fail_addr), 11);
    chk("R8 high pass ran first", int'({saw_hi, saw_lo}), 3);

    // R9 zero count
    clear_model(1, 16'h1111);
    run_job(4'd3, 5'd0);
    chk("R9 zero count done", int'({done, fail, busy}), 4);
    chk("R9 zero count no pulse", seen[3], 0);

    // R9 request while busy is ignored; status held
    clear_model(1, 16'h7777);
    @(negedge clk);
    req_valid = 1; req_base = 4'd8; req_count = 5'd1;
    @(negedge clk);
    req_base = 4'd3;
    @(negedge clk);
    chk("R9 not ready while busy", int'(req_ready), 0);
    repeat (8) @(negedge clk);
    req_valid = 0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R9 status held", int'({done, fail, busy}), 4);
    chk("R9 ignored request untouched", int'({cells[3] == 16'hFFFF, seen[3] == 0}), 3);
    chk("R9 accepted job written", int'(cells[8]), 16'h7777);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule